// File: doc/BRIEF.md
# Multi-Standard Audio Frame Serializer

This block is the serial engine of a full-duplex audio port that owns the frame timing. It shifts transmit samples out, captures receive samples from the serial input, and drives the serial bit clock and the word-select line. Bit timing comes from two strobes supplied by an external clock generator: a launch strobe, on which outgoing bits and word select change, and a sample strobe, on which the incoming bit is captured. The block carries no clock divider, FIFO or register file. Samples enter and leave through valid/ready handshakes on right-aligned 32-bit words.

Four framing styles are available: the Philips style, where word select leads the data by one bit; left-aligned; right-aligned, with zero padding ahead of the data; and a PCM style, with a one-bit sync pulse one bit ahead of the first slot. Data length (16, 24 or 32 bits) and slot length (16 or 32 bits) are set separately. A polarity control swaps the word-select levels. A single-slot (mono) frame is available in PCM framing only. After enable, the frame does not start until a first transmit sample is offered. In receive-only use, one dummy transmit word therefore starts the capture. A missing transmit sample and a received sample that has nowhere to go are each reported by a one-cycle pulse.

Top module: `audio_frame_serializer`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any cycle with `en` low, `sck_o`, `ws_o`, `sd_o`, `rx_valid`, `underrun` and `overrun` are 0. Dropping `en` abandons the frame.
- R2: With `en` high, no frame activity takes place until a `fall_tick` arrives while `tx_valid` is high: `sck_o` stays 0 and `tx_ready` stays 0. That launch emits one lead bit with zero data, and slot 0 of the first frame follows.
- R3: `std_sel`=0 (Philips): `ws_o` changes one bit before the MSB of each slot. The data of each slot is left-aligned in the slot.
- R4: `std_sel`=1 (left-aligned): `ws_o` changes on the same bit as the MSB of each slot. Bits after the data, up to the end of the slot, are 0.
- R5: `std_sel`=2 (right-aligned): the LSB is on the last bit of the slot. The bits ahead of the MSB are 0.
- R6: `std_sel`=3 (PCM): `ws_o` is high for exactly the last bit of each frame, which is one bit before the MSB of slot 0. The slots follow back to back. With `mono`=1 the frame has a single slot.
- R7: Without inversion, `ws_o` is 0 during slot 0 (left) and 1 during slot 1 in the stereo styles. `ws_invert`=1 inverts `ws_o` in every style while running.
- R8: `dlen_sel` 0/1/2/3 selects 16/24/32/32 data bits. `slot32`=1 selects 32-bit slots, and any data length above 16 also forces 32-bit slots. Bits go out MSB first, taken from the low bits of `tx_data`.
- R9: `mono` has no effect unless `std_sel`=3: the other styles always carry two slots.
- R10: When a slot starts and `tx_valid` is low, the slot carries all zeros and `underrun` pulses for one cycle.
- R11: When a slot completes while `rx_valid` is high and `rx_ready` is low, the new sample is dropped, `overrun` pulses for one cycle, and `rx_data`/`rx_chan` keep the older sample.
- R12: `sd_in` is sampled on `rise_tick`. At the end of each slot, the received data bits appear right-aligned on `rx_data`, upper bits zero, with `rx_chan` giving the slot index. They are held with `rx_valid` until `rx_ready`.
- R13: `tx_ready` is high only in a `fall_tick` cycle that starts a slot. Exactly one word is taken per slot.
- R14: `sck_o` goes to 0 on each `fall_tick` and to 1 on each `rise_tick` while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Port enable; low forces idle |
| fall_tick | input | 1 | Launch strobe, one per bit |
| rise_tick | input | 1 | Sample strobe, one per bit, between launch strobes |
| std_sel | input | 2 | Framing style: 0 Philips, 1 left, 2 right, 3 PCM |
| dlen_sel | input | 2 | Data length: 0=16, 1=24, 2/3=32 |
| slot32 | input | 1 | Slot length 32 (1) or 16 (0) |
| ws_invert | input | 1 | Invert word select |
| mono | input | 1 | Single slot per frame (PCM only) |
| tx_data | input | 32 | Transmit sample, right-aligned |
| tx_valid | input | 1 | Transmit sample offered |
| tx_ready | output | 1 | Transmit sample taken this cycle |
| sd_in | input | 1 | Serial data input |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select / frame sync |
| sd_o | output | 1 | Serial data output |
| rx_data | output | 32 | Received sample, right-aligned |
| rx_valid | output | 1 | Received sample held |
| rx_ready | input | 1 | Received sample accepted |
| rx_chan | output | 1 | Slot index of the received sample |
| underrun | output | 1 | Slot started with no transmit data |
| overrun | output | 1 | Received sample dropped |

## Verification
The checks assume that `fall_tick` and `rise_tick` are single-cycle strobes that never coincide and that alternate, with at least one idle cycle between them. They also assume that the framing, length, polarity and mono controls change only while `en` is low. The bench generates each bit period as four clock cycles: launch strobe, gap, sample strobe, gap. It changes the configuration only after it has dropped `en` for two cycles. This keeps every run within those assumptions, and the serial output is fed back to `sd_in` to check capture against transmission.

// File: rtl/afs_pkg.sv
package afs_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int BIT_W  = IDX_W + 1;

    typedef enum logic [1:0] {
        STD_PHIL  = 2'd0,
        STD_LEFT  = 2'd1,
        STD_RIGHT = 2'd2,
        STD_PCM   = 2'd3
    } std_e;

    typedef struct packed {
        logic             run;
        logic             lead;
        logic             sck;
        logic [BIT_W-1:0] bpos;
    } timer_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              sd;
        logic              ws;
        logic              und;
    } txreg_t;

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] data;
        logic              valid;
        logic              chan;
        logic              ovr;
    } rxreg_t;

    function automatic logic [BIT_W-1:0] frame_end_f(input logic long_slot,
                                                     input logic two_slots);
        int unsigned n;
        n = (long_slot ? WORD_W : WORD_W / 2) * (two_slots ? 2 : 1);
        return BIT_W'(n - 1);
    endfunction

endpackage

// File: rtl/afs_slot_decode.sv
module afs_slot_decode
    import afs_pkg::*;
(
    input  std_e             std_sel,
    input  logic             long_slot,
    input  logic             two_slots,
    input  logic [IDX_W:0]   dbits,
    input  logic [BIT_W-1:0] bpos,
    output logic             ws_raw,
    output logic             has_data,
    output logic [IDX_W-1:0] idx,
    output logic             slot,
    output logic             first,
    output logic             last
);
    localparam logic [IDX_W:0] LAST_LONG  = (IDX_W+1)'(WORD_W - 1);
    localparam logic [IDX_W:0] LAST_SHORT = (IDX_W+1)'(WORD_W / 2 - 1);

    logic [IDX_W-1:0] pos;
    logic [BIT_W-1:0] fend, bnext;
    logic [IDX_W:0]   lastp, lpos, rpos, widx;

    always_comb begin
        fend  = frame_end_f(long_slot, two_slots);
        pos   = long_slot ? bpos[IDX_W-1:0] : {1'b0, bpos[IDX_W-2:0]};
        slot  = long_slot ? bpos[IDX_W] : bpos[IDX_W-1];
        bnext = (bpos == fend) ? '0 : bpos + 1'b1;
        lastp = long_slot ? LAST_LONG : LAST_SHORT;
        lpos  = {1'b0, pos};
        rpos  = lastp - lpos;
        first = (pos == '0);
        last  = (lpos == lastp);

        // word select per framing style, before polarity
        case (std_sel)
            STD_PHIL: ws_raw = long_slot ? bnext[IDX_W] : bnext[IDX_W-1];
            STD_PCM:  ws_raw = (bpos == fend);
            default:  ws_raw = slot;
        endcase

        // which data bit sits at this slot position
        if (std_sel == STD_RIGHT) begin
            has_data = (rpos < dbits);
            widx     = rpos;
        end else begin
            has_data = (lpos < dbits);
            widx     = dbits - lpos - 1'b1;
        end
        idx = widx[IDX_W-1:0];
    end
endmodule

// File: rtl/afs_bit_timer.sv
module afs_bit_timer
    import afs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fall_tick,
    input  logic             rise_tick,
    input  logic             tx_valid,
    input  logic [BIT_W-1:0] frame_end,
    output logic             run,
    output logic             lead,
    output logic             sck,
    output logic             step,
    output logic [BIT_W-1:0] bpos,
    output logic [BIT_W-1:0] bnext
);
    timer_t t_q, t_d;

    always_comb begin
        t_d  = t_q;
        step = en && fall_tick && (t_q.run || tx_valid);
        if (!t_q.run)
            bnext = frame_end;
        else if (t_q.bpos == frame_end)
            bnext = '0;
        else
            bnext = t_q.bpos + 1'b1;

        if (step) begin
            t_d.run  = 1'b1;
            t_d.lead = !t_q.run;
            t_d.sck  = 1'b0;
            t_d.bpos = bnext;
        end else if (en && rise_tick && t_q.run) begin
            t_d.sck = 1'b1;
        end
        if (!en) t_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign run  = t_q.run;
    assign lead = t_q.lead;
    assign sck  = t_q.sck;
    assign bpos = t_q.bpos;
endmodule

// File: rtl/afs_rx_assembler.sv
module afs_rx_assembler
    import afs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              active,
    input  logic              rise_tick,
    input  logic              sd_in,
    input  logic              has_data,
    input  logic [IDX_W-1:0]  idx,
    input  logic              slot,
    input  logic              last,
    input  logic              rx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_chan,
    output logic              overrun
);
    rxreg_t r_q, r_d;
    logic [WORD_W-1:0] acc_n;

    always_comb begin
        r_d     = r_q;
        r_d.ovr = 1'b0;
        acc_n   = r_q.acc;
        if (r_q.valid && rx_ready) r_d.valid = 1'b0;
        if (active && rise_tick) begin
            if (has_data) acc_n[idx] = sd_in;
            if (last) begin
                if (r_q.valid && !rx_ready) begin
                    r_d.ovr = 1'b1;
                end else begin
                    r_d.data  = acc_n;
                    r_d.valid = 1'b1;
                    r_d.chan  = slot;
                end
                r_d.acc = '0;
            end else begin
                r_d.acc = acc_n;
            end
        end
        if (!en) r_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_data  = r_q.data;
    assign rx_valid = r_q.valid;
    assign rx_chan  = r_q.chan;
    assign overrun  = r_q.ovr;
endmodule

// File: rtl/audio_frame_serializer.sv
module audio_frame_serializer
    import afs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fall_tick,
    input  logic              rise_tick,
    input  logic [1:0]        std_sel,
    input  logic [1:0]        dlen_sel,
    input  logic              slot32,
    input  logic              ws_invert,
    input  logic              mono,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              sd_in,
    output logic              sck_o,
    output logic              ws_o,
    output logic              sd_o,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              rx_chan,
    output logic              underrun,
    output logic              overrun
);
    std_e             std_c;
    logic             long_slot, two_slots;
    logic [IDX_W:0]   dbits;
    logic [BIT_W-1:0] frame_end, bpos, bnext;
    logic             run, lead, step;

    always_comb begin
        std_c     = std_e'(std_sel);
        long_slot = slot32 || (dlen_sel != 2'd0);
        two_slots = !((std_c == STD_PCM) && mono);
        case (dlen_sel)
            2'd0:    dbits = (IDX_W+1)'(16);
            2'd1:    dbits = (IDX_W+1)'(24);
            default: dbits = (IDX_W+1)'(32);
        endcase
        frame_end = frame_end_f(long_slot, two_slots);
    end

    afs_bit_timer u_timer (
        .clk(clk), .rst_n(rst_n), .en(en),
        .fall_tick(fall_tick), .rise_tick(rise_tick), .tx_valid(tx_valid),
        .frame_end(frame_end),
        .run(run), .lead(lead), .sck(sck_o), .step(step),
        .bpos(bpos), .bnext(bnext)
    );

    // launch side: decode of the bit about to be driven
    logic             n_ws, n_has, n_slot, n_first, n_last;
    logic [IDX_W-1:0] n_idx;
    afs_slot_decode u_dec_launch (
        .std_sel(std_c), .long_slot(long_slot), .two_slots(two_slots),
        .dbits(dbits), .bpos(bnext),
        .ws_raw(n_ws), .has_data(n_has), .idx(n_idx), .slot(n_slot),
        .first(n_first), .last(n_last)
    );

    // sample side: decode of the bit currently on the line
    logic             c_ws, c_has, c_slot, c_first, c_last;
    logic [IDX_W-1:0] c_idx;
    afs_slot_decode u_dec_sample (
        .std_sel(std_c), .long_slot(long_slot), .two_slots(two_slots),
        .dbits(dbits), .bpos(bpos),
        .ws_raw(c_ws), .has_data(c_has), .idx(c_idx), .slot(c_slot),
        .first(c_first), .last(c_last)
    );

    txreg_t            x_q, x_d;
    logic              load;
    logic [WORD_W-1:0] word_n;

    always_comb begin
        x_d     = x_q;
        x_d.und = 1'b0;
        load    = step && run && n_first;
        word_n  = run ? x_q.word : '0;
        if (load) word_n = tx_valid ? tx_data : '0;
        if (step) begin
            x_d.word = word_n;
            x_d.und  = load && !tx_valid;
            x_d.sd   = n_has ? word_n[n_idx] : 1'b0;
            x_d.ws   = n_ws ^ ws_invert;
        end
        if (!en) x_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign tx_ready = load;
    assign sd_o     = x_q.sd;
    assign ws_o     = x_q.ws;
    assign underrun = x_q.und;

    afs_rx_assembler u_rx (
        .clk(clk), .rst_n(rst_n), .en(en),
        .active(run && !lead), .rise_tick(rise_tick), .sd_in(sd_in),
        .has_data(c_has), .idx(c_idx), .slot(c_slot), .last(c_last),
        .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_chan(rx_chan),
        .overrun(overrun)
    );
endmodule

// File: rtl/afs_checker.sv
module afs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic        fall_tick,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        underrun,
    input logic        overrun,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic [31:0] rx_data,
    input logic        sck_o,
    input logic        sd_o,
    input logic        ws_o
);
    a_r1_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sck_o && !sd_o && !ws_o && !rx_valid));

    a_r13_ready_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (fall_tick && en));

    a_r10_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $past(tx_ready && !tx_valid));

    a_r11_overrun_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (rx_valid && $stable(rx_data)));

    a_r12_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && en) |=> (rx_valid && $stable(rx_data)));
endmodule

bind audio_frame_serializer afs_checker u_afs_checker (
    .clk(clk), .rst_n(rst_n), .en(en), .fall_tick(fall_tick),
    .tx_valid(tx_valid), .tx_ready(tx_ready),
    .underrun(underrun), .overrun(overrun),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sck_o(sck_o), .sd_o(sd_o), .ws_o(ws_o)
);

// File: tb/tb_audio_frame_serializer.sv
module tb_audio_frame_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, fall_tick = 1'b0, rise_tick = 1'b0;
    logic [1:0]  std_sel = 2'd0, dlen_sel = 2'd0;
    logic        slot32 = 1'b0, ws_invert = 1'b0, mono = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_valid = 1'b0, rx_ready = 1'b0;
    logic        tx_ready, sck_o, ws_o, sd_o, rx_valid, rx_chan, underrun, overrun;
    logic [31:0] rx_data;
    logic        sd_in;

    assign sd_in = sd_o;   // loopback

    audio_frame_serializer dut (
        .clk(clk), .rst_n(rst_n), .en(en), .fall_tick(fall_tick), .rise_tick(rise_tick),
        .std_sel(std_sel), .dlen_sel(dlen_sel), .slot32(slot32), .ws_invert(ws_invert),
        .mono(mono), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .sd_in(sd_in), .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_chan(rx_chan),
        .underrun(underrun), .overrun(overrun)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0, fails = 0;
    int cycles = 0;
    int rxn = 0, und_cnt = 0, ovr_cnt = 0, cons = 0, sck_rises = 0, ready_seen = 0;
    logic [31:0] rxw [0:15];
    logic        rxc [0:15];
    logic        sck_prev = 1'b0;
    logic        s_ws, s_sd, s_sck_lo, s_sck_hi;

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=150000 cycles", cycles);
            report();
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid && rx_ready && rxn < 16) begin
                rxw[rxn] = rx_data; rxc[rxn] = rx_chan; rxn++;
            end
            if (underrun) und_cnt++;
            if (overrun) ovr_cnt++;
            if (sck_o && !sck_prev) sck_rises++;
            if (tx_ready) ready_seen++;
            sck_prev = sck_o;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] wg(input int k);
        return (32'h9E37_79B9 * (k + 3)) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] mk(input int d);
        return (d == 32) ? 32'hFFFF_FFFF : ((32'h1 << d) - 1);
    endfunction

    // one bit period: launch strobe, gap, sample strobe, gap
    task automatic one_bit(input bit starve);
        bit got;
        @(negedge clk) fall_tick = 1'b1;
        #1 got = tx_ready && tx_valid;
        @(negedge clk) fall_tick = 1'b0;
        if (got) begin
            cons++;
            if (starve) tx_valid = 1'b0;
            tx_data = wg(cons);
        end
        s_ws = ws_o; s_sd = sd_o; s_sck_lo = sck_o;
        @(negedge clk) rise_tick = 1'b1;
        @(negedge clk) rise_tick = 1'b0;
        s_sck_hi = sck_o;
    endtask

    task automatic setup(input logic [1:0] st, input logic [1:0] dl, input logic sl,
                         input logic inv, input logic mo);
        en = 1'b0;
        repeat (2) @(negedge clk);
        std_sel = st; dlen_sel = dl; slot32 = sl; ws_invert = inv; mono = mo;
        rxn = 0; und_cnt = 0; ovr_cnt = 0; cons = 0; sck_rises = 0; ready_seen = 0;
        tx_data = wg(0); tx_valid = 1'b1; rx_ready = 1'b1;
        @(negedge clk) en = 1'b1;
    endtask

    function automatic bit exp_ws(input int st, input int l, input int f, input int b,
                                  input bit inv);
        int bn; bit w;
        bn = (b == f - 1) ? 0 : b + 1;
        case (st)
            0: w = (bn >= l);
            3: w = (b == f - 1);
            default: w = (b >= l);
        endcase
        return w ^ inv;
    endfunction

    function automatic bit exp_sd(input int st, input int l, input int d, input int b,
                                  input logic [31:0] w);
        int p, r;
        p = b % l;
        if (st == 2) begin
            r = l - 1 - p;
            return (r < d) ? w[r] : 1'b0;
        end
        return (p < d) ? w[d - 1 - p] : 1'b0;
    endfunction

    task automatic run_frames(input int st, input int dl, input bit sl, input bit inv,
                              input bit mo, input int nfr, input bit starve, input string req);
        int l, d, nsl, f, ws_bad, sd_bad, sck_bad, rx_bad;
        l = (sl || dl != 0) ? 32 : 16;
        d = (dl == 0) ? 16 : (dl == 1) ? 24 : 32;
        nsl = (st == 3 && mo) ? 1 : 2;
        f = nsl * l;
        ws_bad = 0; sd_bad = 0; sck_bad = 0; rx_bad = 0;
        setup(2'(st), 2'(dl), sl, inv, mo);
        for (int n = 0; n <= nfr * f; n++) begin
            int b, k; logic [31:0] w;
            one_bit(starve);
            if (n == 0) begin b = f - 1; w = '0; end
            else begin
                b = (n - 1) % f;
                k = ((n - 1) / f) * nsl + ((b >= l) ? 1 : 0);
                w = (starve && k > 0) ? 32'h0 : wg(k);
            end
            if (s_ws !== exp_ws(st, l, f, b, inv)) ws_bad++;
            if (s_sd !== exp_sd(st, l, d, b, w)) sd_bad++;
            if (s_sck_lo !== 1'b0 || s_sck_hi !== 1'b1) sck_bad++;
        end
        @(negedge clk);
        chk(ws_bad == 0, req, "word-select bit mismatches", ws_bad, 0);
        chk(sd_bad == 0, req, "serial data bit mismatches (R8 MSB first)", sd_bad, 0);
        chk(sck_bad == 0, "R14", "bit clock level mismatches", sck_bad, 0);
        chk(rxn == nfr * nsl, "R12", "received sample count", rxn, nfr * nsl);
        for (int k = 0; k < rxn; k++) begin
            logic [31:0] e;
            e = ((starve && k > 0) ? 32'h0 : wg(k)) & mk(d);
            if (rxw[k] !== e || rxc[k] !== 1'(k % nsl)) rx_bad++;
        end
        chk(rx_bad == 0, "R12", "received word or slot index mismatches", rx_bad, 0);
        chk(cons == (starve ? 1 : nfr * nsl), "R13", "words taken", cons,
            starve ? 1 : nfr * nsl);
        chk(und_cnt == (starve ? nfr * nsl - 1 : 0), "R10", "underrun pulses", und_cnt,
            starve ? nfr * nsl - 1 : 0);
        chk(ovr_cnt == 0, "R11", "overrun pulses in a drained run", ovr_cnt, 0);
    endtask

    task automatic t_reset;
        chk({sck_o, ws_o, sd_o, rx_valid, underrun, overrun, tx_ready} == 7'b0, "R1",
            "outputs in reset", {sck_o, ws_o, sd_o, rx_valid, underrun, overrun, tx_ready}, 0);
    endtask

    task automatic t_wait_for_kick;
        setup(2'd1, 2'd0, 1'b0, 1'b0, 1'b0);
        tx_valid = 1'b0;
        for (int i = 0; i < 6; i++) one_bit(1'b0);
        chk(sck_rises == 0, "R2", "bit clock edges before first sample", sck_rises, 0);
        chk(ready_seen == 0, "R2", "ready before first sample", ready_seen, 0);
        tx_valid = 1'b1;
        one_bit(1'b0);
        chk(cons == 0 && s_sd == 1'b0, "R2", "lead bit takes no word, sends 0", cons, 0);
        one_bit(1'b0);
        chk(cons == 1 && s_sd == wg(0)[15], "R2", "first slot starts after lead bit",
            s_sd, wg(0)[15]);
    endtask

    task automatic t_overrun;
        setup(2'd1, 2'd0, 1'b0, 1'b0, 1'b0);
        rx_ready = 1'b0;
        for (int n = 0; n <= 32; n++) one_bit(1'b0);
        @(negedge clk);
        chk(ovr_cnt == 1, "R11", "overrun pulses", ovr_cnt, 1);
        chk(rx_valid && rx_data == (wg(0) & 32'hFFFF) && rx_chan == 1'b0, "R11",
            "older sample kept", rx_data, wg(0) & 32'hFFFF);
        rx_ready = 1'b1;
    endtask

    task automatic t_disable;
        setup(2'd0, 2'd2, 1'b1, 1'b1, 1'b0);
        for (int n = 0; n < 10; n++) one_bit(1'b0);
        en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk({sck_o, ws_o, sd_o, rx_valid} == 4'b0, "R1", "idle after disable",
            {sck_o, ws_o, sd_o, rx_valid}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_wait_for_kick();
        run_frames(0, 0, 0, 0, 0, 2, 0, "R3");
        run_frames(1, 2, 1, 0, 0, 2, 0, "R4");
        run_frames(2, 1, 0, 0, 0, 2, 0, "R5");
        run_frames(2, 0, 1, 0, 0, 1, 0, "R5");
        run_frames(3, 0, 0, 0, 0, 2, 0, "R6");
        run_frames(3, 2, 1, 0, 1, 3, 0, "R6");
        run_frames(0, 0, 1, 1, 0, 1, 0, "R7");
        run_frames(3, 0, 0, 1, 0, 1, 0, "R7");
        run_frames(1, 1, 1, 0, 1, 1, 0, "R9");
        run_frames(1, 0, 0, 0, 0, 1, 1, "R10");
        t_overrun();
        t_disable();
        report();
        $finish;
    end
endmodule